// File: doc/BRIEF.md
# Decimated Trace Capture

This block records a stream of samples from one of four input lanes into a 1024-entry trace memory. A free-running sample counter advances on every clock. The write address is built from counter bits, and a 6-bit decimation mask decides, bit by bit, whether each of the middle address bits comes from a fast low counter bit or from a slow counter bit eight places higher. Setting mask bits makes the buffer fill more slowly, so the buffer can cover a longer stretch of time.

Capture runs only while the enable input is high. A write happens on an enabled clock only when the computed address differs from the address of the previous write, so repeated visits to the same slot are skipped. The counter value at each write is latched and presented on an output, and the memory is read through a registered port with a one-clock latency. A synchronous clear restarts the counter and zeroes the latched value.

Top module: `trace_capture`

## Requirements
- R1: The sample counter starts at zero after clear and advances by one on every clock that clear is low, wrapping at its width (18 bits by default).
- R2: Write address bits 1:0 are counter bits 1:0; for i = 0..5, address bit i+2 is counter bit i+10 when decim[i] is 1 and counter bit i+2 when it is 0; address bits 9:8 are counter bits 17:16.
- R3: No write takes place on a clock where trace_en is low or clear is high.
- R4: With trace_en high, a write takes place when the computed address differs from the previous write's address; the first enabled clock after clear always writes.
- R5: The word written is lane chan_sel of chan_data, where lane k occupies bits k*DATA_W+DATA_W-1 down to k*DATA_W.
- R6: last_cnt holds the counter value of the most recent write and is zero after clear.
- R7: rd_data shows the memory word at rd_addr one clock after rd_addr is presented.
- R8: While trace_en is low, last_cnt and the memory contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| clear | input | 1 | Synchronous clear, active high |
| trace_en | input | 1 | Capture enable |
| chan_sel | input | 2 | Lane to record |
| decim | input | 6 | Per-bit decimation mask |
| chan_data | input | 4*DATA_W | Packed lane samples |
| rd_addr | input | 10 | Read address |
| rd_data | output | DATA_W | Registered read data |
| last_cnt | output | CNT_W | Counter value at the latest write |

## Verification
The assertions watch, on every cycle, that no write occurs while capture is disabled, that two consecutive writes never share an address, that the latched counter follows each write and holds still while disabled, and that clear zeroes it. The address mapping, the lane steering and the read latency can only be shown by the bench, which fills the memory under several masks and lanes, including stretches where the counter's upper bits are set, and reads back every slot it expects to hold data. Skipped writes for revisited slots are shown by a sparse enable pattern with a slow mask.

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 18,
  parameter int NCH    = 4
) (
  input  logic                    clk,
  input  logic                    clear,
  input  logic                    trace_en,
  input  logic [1:0]              chan_sel,
  input  logic [5:0]              decim,
  input  logic [NCH*DATA_W-1:0]   chan_data,
  input  logic [9:0]              rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [CNT_W-1:0]        last_cnt
);
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic [CNT_W-1:0]  cnt;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     prev_addr;
  logic              seen;
  logic              wr_en;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] mem [DEPTH];

  assign wr_addr[1:0] = cnt[1:0];

  for (genvar i = 0; i < 6; i++) begin : g_mix
    assign wr_addr[i+2] = decim[i] ? cnt[i+10] : cnt[i+2];
  end

  if (CNT_W >= 18) begin : g_wide
    assign wr_addr[9:8] = cnt[17:16];
  end else begin : g_narrow
    assign wr_addr[9:8] = cnt[9:8];
  end

  assign sample = chan_data[chan_sel*DATA_W +: DATA_W];
  assign wr_en  = !clear && trace_en && (!seen || wr_addr != prev_addr);

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt       <= '0;
      last_cnt  <= '0;
      prev_addr <= '0;
      seen      <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wr_en) begin
        last_cnt  <= cnt;
        prev_addr <= wr_addr;
        seen      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= sample;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             clear,
  input logic             trace_en,
  input logic             wr_en,
  input logic [9:0]       wr_addr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last_cnt
);
  assert_write_gated_R3: assert property (@(posedge clk) disable iff (clear)
    !trace_en |-> !wr_en);

  assert_new_addr_R4: assert property (@(posedge clk) disable iff (clear)
    wr_en |=> (!wr_en || wr_addr != $past(wr_addr)));

  assert_latch_cnt_R6: assert property (@(posedge clk) disable iff (clear)
    wr_en |=> last_cnt == $past(cnt));

  assert_clear_zero_R6: assert property (@(posedge clk)
    clear |=> last_cnt == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (clear)
    !trace_en |=> $stable(last_cnt));
endmodule

bind trace_capture trace_capture_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .clear(clear), .trace_en(trace_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .cnt(cnt), .last_cnt(last_cnt)
);

// File: tb/trace_capture_tb.sv
module trace_capture_tb_top;
  localparam int DW = 12;
  localparam int CW = 18;

  logic           clk = 1'b0;
  logic           clear = 1'b1;
  logic           trace_en = 1'b0;
  logic [1:0]     chan_sel = '0;
  logic [5:0]     decim = '0;
  logic [4*DW-1:0] chan_data = '0;
  logic [9:0]     rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic [CW-1:0]  last_cnt;

  int checks = 0;
  int errors = 0;
  int bcyc = 0;
  bit done = 1'b0;

  logic [CW-1:0] m_cnt = '0;
  logic [CW-1:0] m_last = '0;
  logic [9:0]    m_la = '0;
  bit            m_seen = 1'b0;
  logic [DW-1:0] m_mem [1024];
  bit            m_valid [1024];
  int            m_writes = 0;

  always #5 clk = ~clk;

  trace_capture #(.DATA_W(DW), .CNT_W(CW), .NCH(4)) dut_i (
    .clk(clk), .clear(clear), .trace_en(trace_en), .chan_sel(chan_sel),
    .decim(decim), .chan_data(chan_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .last_cnt(last_cnt)
  );

  function automatic logic [9:0] addr_of(logic [CW-1:0] c, logic [5:0] d);
    logic [9:0] a;
    a[1:0] = c[1:0];
    for (int i = 0; i < 6; i++) a[i+2] = d[i] ? c[i+10] : c[i+2];
    a[9:8] = c[17:16];
    return a;
  endfunction

  always @(posedge clk) begin
    logic [9:0] a;
    a = addr_of(m_cnt, decim);
    if (clear) begin
      m_cnt <= '0; m_last <= '0; m_la <= '0; m_seen <= 1'b0;
    end else begin
      m_cnt <= m_cnt + 1'b1;
      if (trace_en && (!m_seen || a != m_la)) begin
        m_mem[a]   <= chan_data[chan_sel*DW +: DW];
        m_valid[a] <= 1'b1;
        m_last     <= m_cnt;
        m_la       <= a;
        m_seen     <= 1'b1;
        m_writes   <= m_writes + 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bcyc++;
    check("R6 R8 last_cnt", 32'(last_cnt), 32'(m_last));
    for (int k = 0; k < 4; k++)
      chan_data[k*DW +: DW] = DW'(bcyc * 37 + k * 977 + 5);
  endtask

  task automatic capture(logic [5:0] d, logic [1:0] s, int n, int period, bit step_chk);
    logic [CW-1:0] prev;
    decim = d; chan_sel = s;
    for (int j = 0; j < n; j++) begin
      trace_en = (j % period) == 0;
      prev = last_cnt;
      tick();
      if (step_chk && j > 0) check("R1 step", 32'(last_cnt), 32'(prev + 1'b1));
    end
    trace_en = 1'b0;
  endtask

  task automatic readback();
    for (int a = 0; a < 1024; a++) begin
      rd_addr = 10'(a);
      tick();
      if (m_valid[a]) check("R2 R5 R7 readback", 32'(rd_data), 32'(m_mem[a]));
    end
  endtask

  initial begin
    int w0;
    logic [CW-1:0] held;
    for (int a = 0; a < 1024; a++) m_valid[a] = 1'b0;
    repeat (3) tick();
    check("R6 reset", 32'(last_cnt), 0);
    clear = 1'b0;

    capture(6'h00, 2'd0, 1100, 1, 1'b1);
    readback();
    capture(6'h3F, 2'd1, 600, 1, 1'b1);
    readback();

    w0 = m_writes;
    capture(6'h3F, 2'd2, 2200, 4, 1'b0);
    check("R4 skipped revisits", 32'(m_writes - w0 < 550), 1);
    readback();

    capture(6'h15, 2'd3, 1100, 1, 1'b1);
    readback();

    held = last_cnt;
    while (m_cnt != 18'h10040) tick();
    check("R8 hold while idle", 32'(last_cnt), 32'(held));
    capture(6'h00, 2'd0, 300, 1, 1'b1);
    readback();

    while (m_cnt != 18'h20040) tick();
    capture(6'h2A, 2'd1, 300, 1, 1'b1);
    readback();

    clear = 1'b1;
    tick();
    check("R6 clear", 32'(last_cnt), 0);
    clear = 1'b0;
    trace_en = 1'b1;
    decim = 6'h00;
    for (int j = 0; j < 4; j++) begin
      tick();
      check("R1 restart", 32'(last_cnt), j);
    end
    trace_en = 1'b0;
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule